// File: doc/BRIEF.md
# Synchronous Serial Byte Transmitter

This block sends one byte at a time over a two-wire clocked serial link: a data line and a shift clock. A host hands over a byte through a valid/ready stream port. Once the byte is taken, it goes out on the data line least significant bit first. When all eight bits are out, a sticky completion flag is set and a one-cycle interrupt request pulse is raised.

The shift clock can come from two places. In internal mode the block divides the system clock to make the shift clock, drives it on its clock pin, and lets it idle high. In external mode the clock pin is an input. The block passes it through a two-flop synchronizer and an edge detector, so all shifting stays in the system clock domain. A configuration bit picks the active edge, rising or falling. The data line only changes on the opposite, inactive edge, so a receiver can sample it on the active edge.

Back-pressure: `s_ready` is high only while no transfer is running. A byte is taken in a cycle where `s_valid` and `s_ready` are both high. A byte presented while a transfer runs just waits, and nothing in the current transfer changes.

Top module: `sync_shift_tx`

## Requirements
- R1: `s_ready` is low whenever `busy` is high. A byte is accepted on a clock edge where `s_valid` and `s_ready` are both high, and `busy` is high from the next cycle on. Data presented while busy does not alter the bits being sent.
- R2: Every transfer carries exactly 8 bits, bit 0 first and bit 7 last, as seen on `txd` at the active clock edges.
- R3: In internal mode (`cfg_clk_int`=1), `sclk_oe` is high. `sclk_out` makes exactly 16 transitions (8 pulses) per byte. It is high whenever no transfer is running. Each half period lasts `cfg_div`+1 system clock cycles.
- R4: In external mode (`cfg_clk_int`=0), `sclk_oe` is low and the block never completes without external edges. Inactive edges seen before the first active edge do not shift data.
- R5: With `cfg_fall_edge`=0 the rising edge is active; with `cfg_fall_edge`=1 the falling edge is active. `txd` never changes on the cycle the generated clock makes its active transition.
- R6: After the 8th bit, `done_flag` is set, `busy` falls, and `irq` pulses high for exactly one cycle, in the same cycle `done_flag` rises.
- R7: `done_flag` stays set until `flag_clr` is pulsed or a new byte is accepted.
- R8: After reset `txd` is 1. Between transfers `txd` holds the last bit sent (bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_int | input | 1 | 1: generate the shift clock, 0: use the external clock |
| cfg_fall_edge | input | 1 | 0: rising edge active, 1: falling edge active |
| cfg_div | input | DIV_W | Half period of the generated clock minus one, in system cycles |
| s_valid | input | 1 | Byte offered by the host |
| s_ready | output | 1 | Block can take a byte |
| s_data | input | 8 | Byte to send |
| flag_clr | input | 1 | Clears the completion flag |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Drive enable for the clock pin |
| txd | output | 1 | Serial data line |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Sticky transfer-complete flag |
| irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
The bench targets these corner cases:
- A rising-edge transfer in internal mode starts with an inactive falling edge. A shifter that advances on that edge would lose bit 0.
- In falling-edge internal mode, the clock must still return high after the 8th active edge. A design that stops early would leave `sclk_out` low at idle.
- In external mode, the bench sends a stray inactive edge before any active edge and holds the clock still for a while. A shifter that starts too soon would skip bits or finish without any clock.
- A byte offered in the middle of a transfer must not corrupt the byte being sent.
- The flag must clear both by an explicit clear and by a new load.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  localparam int BITS  = 8;
  localparam int CNT_W = $clog2(BITS + 1);
  typedef logic [BITS-1:0] sbyte_t;
endpackage

// File: rtl/sstx_clkgen.sv
module sstx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             idle,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt_q;
  logic             tog;

  assign tog     = run && (cnt_q == div);
  assign rise_ev = tog && !sclk;
  assign fall_ev = tog && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b1;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (idle) begin
      cnt_q <= '0;
      sclk  <= 1'b1;
    end else if (run) begin
      if (tog) begin
        cnt_q <= '0;
        sclk  <= ~sclk;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sstx_edge_sync.sv
module sstx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_ev,
  output logic fall_ev
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], async_in};
  end

  assign rise_ev = pipe_q[STAGES-1] && !pipe_q[STAGES];
  assign fall_ev = !pipe_q[STAGES-1] && pipe_q[STAGES];
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
  import sstx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  sbyte_t load_data,
  input  logic   act_ev,
  input  logic   inact_ev,
  input  logic   line_hi,
  input  logic   flag_clr,
  output logic   txd,
  output logic   busy,
  output logic   last_bit,
  output logic   done_flag,
  output logic   irq
);
  sbyte_t           sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             finish;

  assign last_bit = (cnt_q == CNT_W'(BITS));
  assign finish   = busy && last_bit && line_hi;
  assign txd      = sh_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '1;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      busy      <= 1'b0;
      done_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (load) begin
        sh_q      <= load_data;
        cnt_q     <= '0;
        pend_q    <= 1'b0;
        busy      <= 1'b1;
        done_flag <= 1'b0;
      end else if (busy) begin
        if (finish) begin
          busy      <= 1'b0;
          done_flag <= 1'b1;
          irq       <= 1'b1;
        end else if (act_ev && !last_bit) begin
          cnt_q  <= cnt_q + 1'b1;
          pend_q <= 1'b1;
        end else if (inact_ev && pend_q && !last_bit) begin
          sh_q   <= {sh_q[BITS-1], sh_q[BITS-1:1]};
          pend_q <= 1'b0;
        end
      end else if (flag_clr) begin
        done_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_shift_tx.sv
module sync_shift_tx
  import sstx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clk_int,
  input  logic             cfg_fall_edge,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [BITS-1:0]  s_data,
  input  logic             flag_clr,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             txd,
  output logic             busy,
  output logic             done_flag,
  output logic             irq
);
  logic accept, last_bit, gen_run;
  logic g_rise, g_fall, x_rise, x_fall;
  logic rise_ev, fall_ev, act_ev, inact_ev, line_hi;

  assign s_ready = !busy;
  assign accept  = s_valid && s_ready;
  assign sclk_oe = cfg_clk_int;
  assign gen_run = busy && cfg_clk_int && !(last_bit && sclk_out);

  sstx_clkgen #(.DIV_W(DIV_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .restart(accept), .idle(!busy),
    .run(gen_run), .div(cfg_div), .sclk(sclk_out),
    .rise_ev(g_rise), .fall_ev(g_fall)
  );

  sstx_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk_in),
    .rise_ev(x_rise), .fall_ev(x_fall)
  );

  always_comb begin
    rise_ev  = cfg_clk_int ? g_rise : x_rise;
    fall_ev  = cfg_clk_int ? g_fall : x_fall;
    act_ev   = cfg_fall_edge ? fall_ev : rise_ev;
    inact_ev = cfg_fall_edge ? rise_ev : fall_ev;
    line_hi  = cfg_clk_int ? sclk_out : 1'b1;
  end

  sstx_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(s_data),
    .act_ev(act_ev), .inact_ev(inact_ev), .line_hi(line_hi),
    .flag_clr(flag_clr), .txd(txd), .busy(busy), .last_bit(last_bit),
    .done_flag(done_flag), .irq(irq)
  );
endmodule

// File: rtl/sstx_checks.sv
module sstx_checks (
  input logic clk,
  input logic rst_n,
  input logic cfg_clk_int,
  input logic cfg_fall_edge,
  input logic s_valid,
  input logic s_ready,
  input logic sclk_out,
  input logic txd,
  input logic busy,
  input logic done_flag,
  input logic irq
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> busy);

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_int && !busy && !$past(busy)) |-> sclk_out);

  assert_rise_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_int && !cfg_fall_edge && $past(busy) && $rose(sclk_out)) |-> $stable(txd));

  assert_fall_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_int && cfg_fall_edge && $past(busy) && $fell(sclk_out)) |-> $stable(txd));

  assert_irq_with_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_flag && !$past(done_flag)));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_txd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(s_valid && s_ready)) |=> $stable(txd));
endmodule

bind sync_shift_tx sstx_checks u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_clk_int(cfg_clk_int),
  .cfg_fall_edge(cfg_fall_edge), .s_valid(s_valid), .s_ready(s_ready),
  .sclk_out(sclk_out), .txd(txd), .busy(busy), .done_flag(done_flag),
  .irq(irq)
);

// File: tb/sim_sync_shift_tx.sv
module sim_sync_shift_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_clk_int = 1'b1, cfg_fall_edge = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic       s_valid = 1'b0, flag_clr = 1'b0, sclk_in = 1'b1;
  logic [7:0] s_data = 8'h00;
  logic       s_ready, sclk_out, sclk_oe, txd, busy, done_flag, irq;

  int n_chk = 0, n_bad = 0, cyc = 0, irq_cnt = 0;

  always #2.5 clk = ~clk;

  sync_shift_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_clk_int(cfg_clk_int),
    .cfg_fall_edge(cfg_fall_edge), .cfg_div(cfg_div), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .flag_clr(flag_clr),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .txd(txd),
    .busy(busy), .done_flag(done_flag), .irq(irq)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] b, input int k);
    return b[k];
  endfunction

  task automatic load_byte(input logic [7:0] b);
    @(negedge clk);
    s_valid = 1'b1; s_data = b;
    @(negedge clk);
    s_valid = 1'b0;
    chk("R1 busy after accept", busy, 1);
    chk("R1 ready low while busy", s_ready, 0);
    chk("R7 flag cleared by load", done_flag, 0);
  endtask

  task automatic run_int(input logic [7:0] b, input logic fall, input logic [7:0] dv, input bit poke);
    logic [7:0] rx = 8'h00;
    int tog = 0, nact = 0, gap = 0, bad_gap = 0, i0, t = 0;
    logic prev;
    cfg_clk_int = 1'b1; cfg_fall_edge = fall; cfg_div = dv;
    i0 = irq_cnt;
    load_byte(b);
    chk("R3 oe high in internal mode", sclk_oe, 1);
    prev = sclk_out;
    while (busy && t < 5000) begin
      @(negedge clk);
      t++; gap++;
      if (poke && t >= 3 && t <= 6) begin
        s_valid = 1'b1; s_data = ~b;
      end else if (poke && t == 7) begin
        s_valid = 1'b0;
      end
      if (poke && t >= 3 && t <= 6) chk("R1 ready low mid transfer", s_ready, 0);
      if (sclk_out !== prev) begin
        if (tog > 0 && gap != dv + 1) bad_gap++;
        tog++; gap = 0;
        if (sclk_out == !fall) begin
          if (nact < 8) rx[nact] = txd;
          nact++;
        end
        prev = sclk_out;
      end
    end
    s_valid = 1'b0;
    chk("R3 toggles per byte", tog, 16);
    chk("R3 half period", bad_gap, 0);
    chk("R2 bits lsb first", rx, b);
    chk("R5 active edges", nact, 8);
    @(negedge clk);
    chk("R3 clock idles high", sclk_out, 1);
    chk("R6 done flag set", done_flag, 1);
    chk("R6 one irq pulse", irq_cnt - i0, 1);
    chk("R8 txd holds last bit", txd, exp_bit(b, 7));
  endtask

  task automatic run_ext(input logic [7:0] b, input logic fall, input bit pre);
    logic [7:0] rx = 8'h00;
    logic act_lvl, inact_lvl;
    int i0;
    act_lvl = !fall; inact_lvl = fall;
    cfg_clk_int = 1'b0; cfg_fall_edge = fall;
    sclk_in = pre ? act_lvl : inact_lvl;
    repeat (6) @(negedge clk);
    i0 = irq_cnt;
    load_byte(b);
    chk("R4 oe low in external mode", sclk_oe, 0);
    repeat (20) @(negedge clk);
    chk("R4 waits for external clock", busy, 1);
    chk("R4 bit0 present before edges", txd, exp_bit(b, 0));
    for (int k = 0; k < 8; k++) begin
      sclk_in = inact_lvl;
      repeat (6) @(negedge clk);
      rx[k] = txd;
      sclk_in = act_lvl;
      repeat (6) @(negedge clk);
    end
    chk("R2 external bits lsb first", rx, b);
    chk("R4 busy drops after 8 edges", busy, 0);
    chk("R6 done after external transfer", done_flag, 1);
    chk("R6 irq once external", irq_cnt - i0, 1);
    chk("R8 holds last bit external", txd, exp_bit(b, 7));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 txd high after reset", txd, 1);
    chk("R1 ready after reset", s_ready, 1);
    chk("R6 no flag after reset", done_flag, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 idle clock high", sclk_out, 1);

    run_int(8'hA5, 1'b0, 8'd0, 1'b0);
    run_int(8'h3C, 1'b1, 8'd2, 1'b1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R7 flag cleared by host", done_flag, 0);
    repeat (10) @(negedge clk);
    chk("R8 idle txd stable", txd, 1'b0);
    run_ext(8'h81, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk("R7 flag stays set", done_flag, 1);
    run_ext(8'h6E, 1'b1, 1'b1);
    run_ext(8'hF0, 1'b0, 1'b0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin
      logic [7:0] rb;
      rb = 8'($urandom);
      if ($urandom % 2) run_int(rb, 1'($urandom), 8'($urandom % 4), 1'($urandom));
      else              run_ext(rb, 1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule